// File: doc/BRIEF.md
# PCI Command and Addressing Rule Monitor

A passive observer that sits on a conventional parallel PCI bus beside one master and flags violations of command-level protocol rules. Each time the bus leaves idle it decodes the command on the low command/byte-enable nibble, follows a Dual Address Cycle through its second address phase, and then watches the data phases. It does not check parity, 64-bit negotiation or handshake ordering within data phases.

Five families of rules are enforced. The first covers reserved command encodings. The second covers the extra constraints of a Dual Address Cycle. The third is the rule that the master must stay off the request line after a target retries or disconnects it. The fourth is correct holding of the lock signal for a locked transaction. The fifth is the rule that an interrupt line must not be withdrawn before an Interrupt Acknowledge command has been seen. Each rule owns one bit of a sticky error vector. A bit is set on the clock edge that samples the offending cycle, and only reset clears it. All bus inputs are active low, as on the bus.

Top module: `pci_cmd_rule_mon`

## Requirements
- R1: The bus is idle when frameN and irdyN are both high. An address phase is the first clock with frameN low after an idle clock, or the clock after an address phase carrying command 4'b1101. If the command nibble cbe[3:0] in an address phase is 4'b0100, 4'b0101, 4'b1000 or 4'b1001, errFlags[0] is set. Those values outside an address phase have no effect.
- R2: In the second address phase of a Dual Address Cycle (first phase command 4'b1101), irdyN sampled low sets errFlags[1].
- R3: If the second address phase of a Dual Address Cycle again carries 4'b1101 on cbe[3:0], errFlags[2] is set.
- R4: cbe[7:4] in the first Dual Address Cycle phase must equal the command on cbe[3:0] in the second phase. A mismatch sets errFlags[3].
- R5: A termination is stopN low with devselN low during a data phase. It is a retry if trdyN is high and no transfer (irdyN and trdyN both low) has happened yet, and a disconnect otherwise. On each of the 2 clocks after the clock that samples the first termination of a transaction, reqN must be high. reqN low on either of them sets errFlags[4], and reqN low later does not.
- R6: A transaction is locked when lockN is high in its (last) address phase and low on the first data clock. It then sets errFlags[5] if lockN goes high on a busy data clock. errFlags[5] is also set if lockN goes from high to low on a busy data clock after the first one.
- R7: Each intN line that falls becomes pending. An address phase with command 4'b0000 acknowledges all pending lines. A pending line that rises without an acknowledge on the same clock sets errFlags[6].
- R8: Reset clears errFlags to zero. Once set, a bit stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low synchronous reset |
| frameN | input | 1 | Cycle frame, active low |
| irdyN | input | 1 | Initiator ready, active low |
| trdyN | input | 1 | Target ready, active low |
| stopN | input | 1 | Target stop request, active low |
| devselN | input | 1 | Target device select, active low |
| cbe | input | 8 | Command / byte enables, both halves |
| lockN | input | 1 | Bus lock, active low |
| reqN | input | 1 | Request line of the monitored master, active low |
| intN | input | NUM_INT | Interrupt lines, active low |
| errFlags | output | 7 | Sticky rule violation flags, bit per rule |

## Verification
An interrupt line can be released on the very clock that an Interrupt Acknowledge address phase is sampled, so the release rule and the acknowledge decode meet in one cycle. The bench drives that coincidence and expects no interrupt flag, and it also releases a line one clock before the acknowledge and expects the flag. A second collision is provoked in one Dual Address Cycle second phase that has irdyN low and a repeated DAC command at once, where both flags must appear together.

// File: rtl/pci_cmd_rule_pkg.sv
package pci_cmd_rule_pkg;
  localparam int NUM_RULES       = 7;
  localparam int RULE_RESERVED   = 0;
  localparam int RULE_DAC_IRDY   = 1;
  localparam int RULE_DAC_DOUBLE = 2;
  localparam int RULE_DAC_UPPER  = 3;
  localparam int RULE_REQ_GAP    = 4;
  localparam int RULE_LOCK       = 5;
  localparam int RULE_INT_ACK    = 6;

  localparam logic [3:0] CMD_INTACK = 4'b0000;
  localparam logic [3:0] CMD_DAC    = 4'b1101;

  typedef enum logic [1:0] {PH_IDLE, PH_DAC2, PH_DATA} phase_e;

  typedef struct packed {
    logic addrFirst;
    logic addrSecond;
    logic firstData;
    logic dataBusy;
    logic termHit;
  } strobe_t;

  function automatic logic isReserved(input logic [3:0] c);
    return (c == 4'b0100) || (c == 4'b0101) || (c == 4'b1000) || (c == 4'b1001);
  endfunction
endpackage

// File: rtl/pci_cmd_rule_ctrl.sv
module pci_cmd_rule_ctrl
  import pci_cmd_rule_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       frameN,
  input  logic       irdyN,
  input  logic       trdyN,
  input  logic       stopN,
  input  logic       devselN,
  input  logic [3:0] cmdLow,
  output strobe_t    strobes
);
  phase_e phase;
  logic   firstPend;
  logic   xferSeen;
  logic   termSeen;
  logic   busIdle;
  logic   retryNow;
  logic   discNow;

  assign busIdle = frameN & irdyN;

  always_comb begin
    strobes.addrFirst  = (phase == PH_IDLE) && !frameN;
    strobes.addrSecond = (phase == PH_DAC2);
    strobes.firstData  = (phase == PH_DATA) && firstPend;
    strobes.dataBusy   = (phase == PH_DATA) && !busIdle;
    retryNow = strobes.dataBusy && !stopN && !devselN && trdyN && !xferSeen;
    discNow  = strobes.dataBusy && !stopN && !devselN && (xferSeen || !trdyN);
    strobes.termHit = (retryNow || discNow) && !termSeen;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase     <= PH_IDLE;
      firstPend <= 1'b0;
      xferSeen  <= 1'b0;
      termSeen  <= 1'b0;
    end else begin
      case (phase)
        PH_IDLE: begin
          xferSeen <= 1'b0;
          termSeen <= 1'b0;
          if (!frameN) begin
            phase     <= (cmdLow == CMD_DAC) ? PH_DAC2 : PH_DATA;
            firstPend <= (cmdLow != CMD_DAC);
          end
        end
        PH_DAC2: begin
          phase     <= PH_DATA;
          firstPend <= 1'b1;
        end
        PH_DATA: begin
          firstPend <= 1'b0;
          if (!irdyN && !trdyN) xferSeen <= 1'b1;
          if (strobes.termHit)  termSeen <= 1'b1;
          if (busIdle)          phase    <= PH_IDLE;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pci_cmd_rule_datapath.sv
module pci_cmd_rule_datapath
  import pci_cmd_rule_pkg::*;
#(
  parameter int NUM_INT = 4,
  parameter int REQ_GAP = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  strobe_t              strobes,
  input  logic [7:0]           cbe,
  input  logic                 irdyN,
  input  logic                 lockN,
  input  logic                 reqN,
  input  logic [NUM_INT-1:0]   intN,
  output logic [NUM_RULES-1:0] errFlags
);
  localparam int GAP_W = $clog2(REQ_GAP + 1);

  logic [3:0]           upperHeld;
  logic [GAP_W-1:0]     gapCnt;
  logic                 lockFree;
  logic                 lockHeld;
  logic                 lockPrev;
  logic [NUM_INT-1:0]   intPrev;
  logic [NUM_INT-1:0]   intPend;
  logic [NUM_INT-1:0]   intRelease;
  logic [NUM_INT-1:0]   intFall;
  logic [NUM_RULES-1:0] hit;
  logic                 ackSeen;
  logic                 addrAny;
  logic                 lockRelease;
  logic                 lockLate;

  assign addrAny = strobes.addrFirst || strobes.addrSecond;
  assign ackSeen = addrAny && (cbe[3:0] == CMD_INTACK);

  assign lockRelease = strobes.dataBusy && !strobes.firstData && lockHeld && lockN;
  assign lockLate    = strobes.dataBusy && !strobes.firstData && !lockHeld && lockPrev && !lockN;

  always_comb begin
    hit = '0;
    hit[RULE_RESERVED]   = addrAny && isReserved(cbe[3:0]);
    hit[RULE_DAC_IRDY]   = strobes.addrSecond && !irdyN;
    hit[RULE_DAC_DOUBLE] = strobes.addrSecond && (cbe[3:0] == CMD_DAC);
    hit[RULE_DAC_UPPER]  = strobes.addrSecond && (cbe[3:0] != upperHeld);
    hit[RULE_REQ_GAP]    = (gapCnt != '0) && !reqN;
    hit[RULE_LOCK]       = lockRelease || lockLate;
    hit[RULE_INT_ACK]    = (|(intRelease & intPend)) && !ackSeen;
  end

  generate
    for (genvar i = 0; i < NUM_INT; i++) begin : g_intLine
      assign intRelease[i] = !intPrev[i] && intN[i];
      assign intFall[i]    = intPrev[i] && !intN[i];
      always_ff @(posedge clk) begin
        if (!rstN) begin
          intPrev[i] <= 1'b1;
          intPend[i] <= 1'b0;
        end else begin
          intPrev[i] <= intN[i];
          if (intFall[i])                     intPend[i] <= 1'b1;
          else if (ackSeen || intRelease[i])  intPend[i] <= 1'b0;
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      upperHeld <= '0;
      gapCnt    <= '0;
      lockFree  <= 1'b0;
      lockHeld  <= 1'b0;
      lockPrev  <= 1'b1;
      errFlags  <= '0;
    end else begin
      lockPrev <= lockN;
      if (strobes.addrFirst) upperHeld <= cbe[7:4];
      if (addrAny) lockFree <= lockN;
      if (strobes.addrFirst)      lockHeld <= 1'b0;
      else if (strobes.firstData) lockHeld <= lockFree && !lockN;
      if (strobes.termHit)     gapCnt <= GAP_W'(REQ_GAP);
      else if (gapCnt != '0)   gapCnt <= gapCnt - 1'b1;
      errFlags <= errFlags | hit;
    end
  end
endmodule

// File: rtl/pci_cmd_rule_mon.sv
module pci_cmd_rule_mon
  import pci_cmd_rule_pkg::*;
#(
  parameter int NUM_INT = 4,
  parameter int REQ_GAP = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 frameN,
  input  logic                 irdyN,
  input  logic                 trdyN,
  input  logic                 stopN,
  input  logic                 devselN,
  input  logic [7:0]           cbe,
  input  logic                 lockN,
  input  logic                 reqN,
  input  logic [NUM_INT-1:0]   intN,
  output logic [NUM_RULES-1:0] errFlags
);
  strobe_t strobes;

  pci_cmd_rule_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .frameN(frameN), .irdyN(irdyN), .trdyN(trdyN),
    .stopN(stopN), .devselN(devselN), .cmdLow(cbe[3:0]), .strobes(strobes)
  );

  pci_cmd_rule_datapath #(.NUM_INT(NUM_INT), .REQ_GAP(REQ_GAP)) dp_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .cbe(cbe), .irdyN(irdyN),
    .lockN(lockN), .reqN(reqN), .intN(intN), .errFlags(errFlags)
  );
endmodule

// File: rtl/pci_cmd_rule_chk.sv
module pci_cmd_rule_chk
  import pci_cmd_rule_pkg::*;
(
  input logic                 clk,
  input logic                 rstN,
  input logic                 frameN,
  input logic                 irdyN,
  input logic [7:0]           cbe,
  input logic [NUM_RULES-1:0] errFlags
);
  logic prevIdle;
  logic dacNext;
  logic addrNow;

  assign addrNow = prevIdle && !frameN;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevIdle <= 1'b1;
      dacNext  <= 1'b0;
    end else begin
      prevIdle <= frameN && irdyN;
      dacNext  <= addrNow && (cbe[3:0] == CMD_DAC);
    end
  end

  // R1: reserved command in a plain address phase raises its flag
  p_reserved_r1: assert property (@(posedge clk) disable iff (!rstN)
    addrNow && isReserved(cbe[3:0]) |=> errFlags[RULE_RESERVED]);

  // R2: initiator ready during the second DAC phase
  p_dac_irdy_r2: assert property (@(posedge clk) disable iff (!rstN)
    dacNext && !irdyN |=> errFlags[RULE_DAC_IRDY]);

  // R3: repeated DAC command in the second phase
  p_dac_double_r3: assert property (@(posedge clk) disable iff (!rstN)
    dacNext && (cbe[3:0] == CMD_DAC) |=> errFlags[RULE_DAC_DOUBLE]);

  // R8: flags never clear outside reset
  p_sticky_r8: assert property (@(posedge clk) disable iff (!rstN)
    ((errFlags & $past(errFlags)) == $past(errFlags)));

  // R8: reset leaves the flags cleared on the following cycle
  p_reset_clear_r8: assert property (@(posedge clk)
    !rstN |=> (errFlags == '0));
endmodule

bind pci_cmd_rule_mon pci_cmd_rule_chk chk_i (
  .clk(clk), .rstN(rstN), .frameN(frameN), .irdyN(irdyN), .cbe(cbe), .errFlags(errFlags)
);

// File: tb/pci_cmd_rule_mon_tb.sv
module pci_cmd_rule_mon_tb_top;
  localparam int NI = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic frameN, irdyN, trdyN, stopN, devselN, lockN, reqN;
  logic [7:0] cbe;
  logic [NI-1:0] intN;
  logic [6:0] errFlags;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  typedef struct { logic [6:0] exp; string tag; } item_t;
  item_t sbQ[$];

  always #2 clk = ~clk;

  pci_cmd_rule_mon #(.NUM_INT(NI), .REQ_GAP(2)) dut_i (
    .clk(clk), .rstN(rstN), .frameN(frameN), .irdyN(irdyN), .trdyN(trdyN),
    .stopN(stopN), .devselN(devselN), .cbe(cbe), .lockN(lockN), .reqN(reqN),
    .intN(intN), .errFlags(errFlags)
  );

  // monitor: pops expectations and compares away from the rising edge
  initial forever begin
    @(negedge clk);
    if (sbQ.size() > 0) begin
      item_t it;
      it = sbQ.pop_front();
      checks++;
      if (errFlags !== it.exp) begin
        fails++;
        $display("FAIL %s: errFlags actual %b expected %b", it.tag, errFlags, it.exp);
      end
    end
  end

  task automatic expectFlags(input logic [6:0] e, input string tag);
    item_t it;
    it.exp = e;
    it.tag = tag;
    sbQ.push_back(it);
    wait (sbQ.size() == 0);
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic busIdle();
    frameN = 1; irdyN = 1; trdyN = 1; stopN = 1; devselN = 1; cbe = 8'h00;
  endtask

  task automatic doReset();
    rstN = 0; busIdle(); lockN = 1; reqN = 1; intN = '1;
    repeat (2) step();
    rstN = 1;
  endtask

  task automatic addrPhase(input logic [7:0] c);
    frameN = 0; irdyN = 1; cbe = c; step();
  endtask

  task automatic lastData();
    frameN = 1; irdyN = 0; trdyN = 0; devselN = 0; cbe = 8'h00; step();
  endtask

  task automatic simpleTxn(input logic [3:0] cmd);
    addrPhase({4'h0, cmd});
    lastData();
    busIdle(); step();
  endtask

  initial begin
    busIdle(); lockN = 1; reqN = 1; intN = '1;
    doReset();
    expectFlags(7'b0, "R8 reset state");

    // R1: normal read, no flag; reserved 0100; reserved value in data phase ignored
    simpleTxn(4'b0110);
    expectFlags(7'b0, "R1 legal command");
    addrPhase(8'h06); frameN = 1; irdyN = 0; trdyN = 0; devselN = 0; cbe = 8'h04; step();
    busIdle(); step();
    expectFlags(7'b0, "R1 reserved value outside address phase");
    simpleTxn(4'b0100);
    expectFlags(7'b0000001, "R1 reserved 0100");
    repeat (5) step();
    expectFlags(7'b0000001, "R8 flag sticky");
    doReset();
    simpleTxn(4'b1001);
    expectFlags(7'b0000001, "R1 reserved 1001");

    // legal DAC
    doReset();
    addrPhase(8'h6D); addrPhase(8'h06); lastData(); busIdle(); step();
    expectFlags(7'b0, "R4 legal DAC");

    // R2
    doReset();
    addrPhase(8'h6D); frameN = 0; irdyN = 0; cbe = 8'h06; step();
    lastData(); busIdle(); step();
    expectFlags(7'b0000010, "R2 irdy in second DAC phase");

    // R3 (upper nibble matches second command)
    doReset();
    addrPhase(8'hDD); addrPhase(8'h0D); lastData(); busIdle(); step();
    expectFlags(7'b0000100, "R3 DAC after DAC");

    // R2 and R3 in the same cycle
    doReset();
    addrPhase(8'hDD); frameN = 0; irdyN = 0; cbe = 8'h0D; step();
    lastData(); busIdle(); step();
    expectFlags(7'b0000110, "R2 R3 coincident");

    // R4
    doReset();
    addrPhase(8'h7D); addrPhase(8'h06); lastData(); busIdle(); step();
    expectFlags(7'b0001000, "R4 upper command mismatch");

    // R5 retry, req low on first following clock
    doReset();
    addrPhase(8'h06);
    frameN = 1; irdyN = 0; devselN = 0; stopN = 0; trdyN = 1; step();
    busIdle(); reqN = 0; step(); reqN = 1;
    expectFlags(7'b0010000, "R5 retry req early");

    // R5 retry, req low on second following clock
    doReset();
    addrPhase(8'h06);
    frameN = 1; irdyN = 0; devselN = 0; stopN = 0; trdyN = 1; step();
    busIdle(); step(); reqN = 0; step(); reqN = 1;
    expectFlags(7'b0010000, "R5 retry req second clock");

    // R5 disconnect, req kept high two clocks then low
    doReset();
    addrPhase(8'h06);
    frameN = 0; irdyN = 0; trdyN = 0; devselN = 0; cbe = 8'h00; step();
    frameN = 1; trdyN = 1; stopN = 0; step();
    busIdle(); step(); step(); reqN = 0; step(); reqN = 1;
    expectFlags(7'b0, "R5 disconnect gap honoured");

    // R6 good locked transaction
    doReset();
    lockN = 1; addrPhase(8'h06);
    lockN = 0; frameN = 0; irdyN = 0; trdyN = 0; devselN = 0; cbe = 8'h00; step();
    lastData(); busIdle(); lockN = 1; step();
    expectFlags(7'b0, "R6 lock held");

    // R6 released early
    doReset();
    lockN = 1; addrPhase(8'h06);
    lockN = 0; frameN = 0; irdyN = 0; trdyN = 0; devselN = 0; cbe = 8'h00; step();
    lockN = 1; lastData(); busIdle(); step();
    expectFlags(7'b0100000, "R6 lock released early");

    // R6 asserted late
    doReset();
    lockN = 1; addrPhase(8'h06);
    frameN = 0; irdyN = 0; trdyN = 0; devselN = 0; cbe = 8'h00; step();
    lockN = 0; lastData(); busIdle(); lockN = 1; step();
    expectFlags(7'b0100000, "R6 lock asserted late");

    // R7 release with no ack
    doReset();
    intN = 4'b1110; step(); step();
    intN = 4'b1111; step();
    expectFlags(7'b1000000, "R7 release without ack");

    // R7 release after ack
    doReset();
    intN = 4'b1011; step();
    simpleTxn(4'b0000);
    intN = 4'b1111; step();
    expectFlags(7'b0, "R7 release after ack");

    // R7 release on the same clock as the ack address phase
    doReset();
    intN = 4'b1110; step(); step();
    intN = 4'b1111; addrPhase(8'h00);
    lastData(); busIdle(); step();
    expectFlags(7'b0, "R7 release coincident with ack");

    // R7 release one clock before the ack
    doReset();
    intN = 4'b1110; step();
    intN = 4'b1111; step();
    simpleTxn(4'b0000);
    expectFlags(7'b1000000, "R7 release just before ack");

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule